// File: doc/BRIEF.md
# Display Interrupt Status Unit

This unit gathers the event pulses of a multi-channel display controller into two status registers and drives a single level-sensitive interrupt line. Each event arrives as a one-cycle pulse that carries a kind, a channel number and the frame identifier of that channel. Channel 0 events land in a primary status register and are masked from a primary control register. Channels 1 and up land in a secondary status register and are masked from a dedicated mask register. Software reads the registers, clears flags by writing ones, and reads the identifier of the frame that raised the most recent reported event.

The unit also acknowledges two controller-wide conditions. It flags a quick-disable when software drops the enable bit, and it flags a last-frame-done when a frame completes while disable-at-end is armed. In that case the enable bit clears itself. A bus error on any channel records the channel number next to its flag, and that number is cleared together with the flag.

Top module: `disp_irq_status`

## Requirements
- R1: With event kind encoded as 0 start-of-frame, 1 end-of-frame, 2 branch, 3 underrun and 4 bus error, a channel 0 event of kind 0, 1, 2 or 3 sets primary status bit 1, 3, 5 or 4 respectively. Kinds 5 to 7 and channel numbers at or above the channel count have no effect.
- R2: For channels c from 1 to 6, an event of kind k from 0 to 3 sets secondary status bit 8*k + c - 1. The register holds no other bits.
- R3: Primary control bit 8+i masks primary status bit i for i from 0 to 6. A mask register bit masks the secondary status bit at the same position. The interrupt is high when any status bit with a clear mask is set. Primary bit 7 never drives the interrupt.
- R4: An event of kind 0 to 3 whose status bit is unmasked sets the summary bit (primary bit 7) and loads its frame identifier into the identifier register (address 4). A masked event changes neither.
- R5: A bus error (kind 4) on a valid channel sets primary bit 2 and writes the channel number into primary bits [30:28]. It also sets the summary bit and loads the frame identifier, whatever the masks hold.
- R6: Writing address 2 clears each of primary bits [11:0] where the data holds a 1. Clearing bit 2 also zeroes bits [30:28]. Writing address 3 clears the secondary bits where the data holds a 1.
- R7: A control write (address 0) that changes enable (bit 0) from 1 to 0 sets primary bit 6.
- R8: A frame-end pulse while enable and disable-at-end (control bit 1) are both set clears enable and sets primary bit 0. This clear takes priority over a control write in the same cycle.
- R9: Start-of-frame and end-of-frame events are recorded only when the channel's command word has bit 22 (start) or bit 21 (end) set. These two bits arrive as the inputs ev_sof_ie and ev_eof_ie.
- R10: When a status bit is set and cleared in the same cycle, it ends up set. For the bus error, the newly written channel number is kept.
- R11: After reset every register reads zero and the interrupt is low. Control keeps bits 0, 1 and 8 to 14, the mask register keeps bits 0-5, 8-13, 16-21 and 24-29, and addresses 5 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | One-cycle event pulse |
| ev_kind | input | 3 | Event kind code |
| ev_chan | input | 3 | Channel number of the event |
| ev_sof_ie | input | 1 | Start-interrupt enable of the channel's command word |
| ev_eof_ie | input | 1 | End-interrupt enable of the channel's command word |
| ev_fid | input | 32 | Frame identifier of the channel |
| frame_end | input | 1 | Frame completed pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt line |
| enable | output | 1 | Current controller enable bit |

## Verification
The bench builds the unit with its default values: seven channels, a 3-bit channel field and 32-bit data and identifiers. With these values all six secondary channels and all four event groups of the secondary register are in use. The top channel field value 6 can be recorded, and channel code 7 is a legal pin value that must be ignored. Random stimulus therefore reaches out-of-range channels, reserved kind codes, writes to unused addresses, and same-cycle collisions of events, clears, control writes and frame ends.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

   typedef enum logic [2:0] {
      EV_SOF    = 3'd0,
      EV_EOF    = 3'd1,
      EV_BRANCH = 3'd2,
      EV_UNDER  = 3'd3,
      EV_BUSERR = 3'd4
   } ev_kind_e;

   // primary status flag positions
   localparam int A_LFD  = 0;
   localparam int A_SOF0 = 1;
   localparam int A_BERR = 2;
   localparam int A_EOF0 = 3;
   localparam int A_UND0 = 4;
   localparam int A_BS0  = 5;
   localparam int A_QDD  = 6;
   localparam int A_SUM  = 7;

   localparam int A_NFLAG   = 7;    // maskable primary flags
   localparam int A_W1C_W   = 12;   // clearable low field
   localparam int MASK_OFS  = 8;    // control bit of mask for flag 0
   localparam int CTL_EN    = 0;
   localparam int CTL_DAE   = 1;
   localparam int GROUP     = 8;    // secondary bits per event kind
   localparam int NGROUP    = 4;
   localparam int FIELD_LSB = 28;

   localparam logic [2:0] ADR_CTL = 3'd0;
   localparam logic [2:0] ADR_MSK = 3'd1;
   localparam logic [2:0] ADR_STA = 3'd2;
   localparam logic [2:0] ADR_STB = 3'd3;
   localparam logic [2:0] ADR_FID = 3'd4;

   function automatic int a_bit_of(input ev_kind_e k);
      case (k)
         EV_SOF:    return A_SOF0;
         EV_EOF:    return A_EOF0;
         EV_BRANCH: return A_BS0;
         default:   return A_UND0;
      endcase
   endfunction

   function automatic logic [63:0] b_valid_bits(input int nch);
      logic [63:0] v;
      v = '0;
      for (int g = 0; g < NGROUP; g++)
         for (int c = 0; c < nch - 1; c++)
            v[g*GROUP + c] = 1'b1;
      return v;
   endfunction

   function automatic logic [63:0] ctl_valid_bits();
      logic [63:0] v;
      v = '0;
      v[CTL_EN]  = 1'b1;
      v[CTL_DAE] = 1'b1;
      for (int i = 0; i < A_NFLAG; i++) v[MASK_OFS + i] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/dirq_ctrl_regs.sv
module dirq_ctrl_regs
   import dirq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] CTL_VALID = '1,
   parameter logic [DATA_W-1:0] MSK_VALID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic              wr_msk,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_end,
   output logic [DATA_W-1:0] ctl_q,
   output logic [DATA_W-1:0] msk_q,
   output logic              qdd_set,
   output logic              lfd_set
);

   logic [DATA_W-1:0] ctl_d;

   always_comb begin
      lfd_set = frame_end & ctl_q[CTL_EN] & ctl_q[CTL_DAE];
      qdd_set = wr_ctl & ctl_q[CTL_EN] & ~wr_data[CTL_EN];
      ctl_d   = wr_ctl ? (wr_data & CTL_VALID) : ctl_q;
      if (lfd_set) ctl_d[CTL_EN] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         msk_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         if (wr_msk) msk_q <= wr_data & MSK_VALID;
      end
   end

endmodule

// File: rtl/dirq_event_decode.sv
module dirq_event_decode
   import dirq_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int CH_W   = 3,
   parameter int DATA_W = 32
) (
   input  logic               ev_valid,
   input  logic [2:0]         ev_kind,
   input  logic [CH_W-1:0]    ev_chan,
   input  logic               ev_sof_ie,
   input  logic               ev_eof_ie,
   input  logic [A_NFLAG-1:0] mask_a,
   input  logic [DATA_W-1:0]  msk_q,
   output logic [A_W1C_W-1:0] set_a,
   output logic [DATA_W-1:0]  set_b,
   output logic               berr_hit,
   output logic               note_hit
);

   ev_kind_e          kind;
   logic [NUM_CH-1:0] ch_hit;
   logic              flag_ok;
   logic              unmasked;

   assign kind = ev_kind_e'(ev_kind);

   // one comparator per implemented channel
   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign ch_hit[c] = ev_valid && (ev_chan == CH_W'(c));
   end

   always_comb begin
      case (kind)
         EV_SOF:             flag_ok = ev_sof_ie;
         EV_EOF:             flag_ok = ev_eof_ie;
         EV_BRANCH, EV_UNDER: flag_ok = 1'b1;
         default:            flag_ok = 1'b0;
      endcase
   end

   always_comb begin
      int abit;
      int pos;
      set_a    = '0;
      set_b    = '0;
      unmasked = 1'b0;
      abit     = a_bit_of(kind);
      berr_hit = (kind == EV_BUSERR) && (|ch_hit);
      if (flag_ok && ch_hit[0]) begin
         set_a[abit] = 1'b1;
         unmasked    = ~mask_a[abit];
      end
      for (int c = 1; c < NUM_CH; c++) begin
         pos = int'(ev_kind[1:0]) * GROUP + c - 1;
         if (flag_ok && ch_hit[c]) begin
            set_b[pos] = 1'b1;
            unmasked   = ~msk_q[pos];
         end
      end
      note_hit = berr_hit | unmasked;
   end

endmodule

// File: rtl/dirq_status_regs.sv
module dirq_status_regs
   import dirq_pkg::*;
#(
   parameter int CH_W   = 3,
   parameter int DATA_W = 32,
   parameter int FID_W  = 32,
   parameter logic [DATA_W-1:0] MSK_VALID = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [A_W1C_W-1:0] set_a,
   input  logic [DATA_W-1:0]  set_b,
   input  logic               berr_hit,
   input  logic               note_hit,
   input  logic               qdd_set,
   input  logic               lfd_set,
   input  logic [CH_W-1:0]    ev_chan,
   input  logic [FID_W-1:0]   ev_fid,
   input  logic               wr_sta,
   input  logic               wr_stb,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  st_a,
   output logic [DATA_W-1:0]  st_b,
   output logic [FID_W-1:0]   fid_q
);

   logic [A_W1C_W-1:0] flags_q, flags_set, flags_clr;
   logic [CH_W-1:0]    field_q, field_d;
   logic [DATA_W-1:0]  b_clr;

   always_comb begin
      flags_set          = set_a;
      flags_set[A_LFD]   = flags_set[A_LFD]  | lfd_set;
      flags_set[A_QDD]   = flags_set[A_QDD]  | qdd_set;
      flags_set[A_BERR]  = flags_set[A_BERR] | berr_hit;
      flags_set[A_SUM]   = flags_set[A_SUM]  | note_hit;
      flags_clr          = wr_sta ? wr_data[A_W1C_W-1:0] : '0;
      b_clr              = wr_stb ? (wr_data & MSK_VALID) : '0;
      if (berr_hit)                field_d = ev_chan;
      else if (flags_clr[A_BERR])  field_d = '0;
      else                         field_d = field_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         field_q <= '0;
         st_b    <= '0;
         fid_q   <= '0;
      end else begin
         flags_q <= (flags_q & ~flags_clr) | flags_set;
         field_q <= field_d;
         st_b    <= (st_b & ~b_clr) | set_b;
         if (note_hit) fid_q <= ev_fid;
      end
   end

   always_comb begin
      st_a                     = '0;
      st_a[A_W1C_W-1:0]        = flags_q;
      st_a[FIELD_LSB +: CH_W]  = field_q;
   end

endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
   import dirq_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int DATA_W = 32,
   parameter int FID_W  = 32,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [2:0]        ev_kind,
   input  logic [CH_W-1:0]   ev_chan,
   input  logic              ev_sof_ie,
   input  logic              ev_eof_ie,
   input  logic [FID_W-1:0]  ev_fid,
   input  logic              frame_end,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              enable
);

   localparam logic [63:0]       B_ALL     = b_valid_bits(NUM_CH);
   localparam logic [63:0]       C_ALL     = ctl_valid_bits();
   localparam logic [DATA_W-1:0] MSK_VALID = B_ALL[DATA_W-1:0];
   localparam logic [DATA_W-1:0] CTL_VALID = C_ALL[DATA_W-1:0];

   if (NUM_CH < 2 || NUM_CH - 1 > GROUP) begin : g_bad_ch
      $error("disp_irq_status: NUM_CH must lie in 2..%0d", GROUP + 1);
   end
   if (DATA_W < NGROUP * GROUP || DATA_W < FIELD_LSB + CH_W || DATA_W > 64) begin : g_bad_w
      $error("disp_irq_status: DATA_W too narrow for the register layout");
   end
   if (FID_W > DATA_W) begin : g_bad_fid
      $error("disp_irq_status: FID_W must not exceed DATA_W");
   end

   logic [DATA_W-1:0]  ctl_q, msk_q, st_a, st_b, set_b;
   logic [FID_W-1:0]   fid_q;
   logic [A_W1C_W-1:0] set_a;
   logic               qdd_set, lfd_set, berr_hit, note_hit;
   logic               wr_ctl, wr_msk, wr_sta, wr_stb;

   assign wr_ctl = wr_en && (wr_addr == ADR_CTL);
   assign wr_msk = wr_en && (wr_addr == ADR_MSK);
   assign wr_sta = wr_en && (wr_addr == ADR_STA);
   assign wr_stb = wr_en && (wr_addr == ADR_STB);

   dirq_ctrl_regs #(
      .DATA_W(DATA_W), .CTL_VALID(CTL_VALID), .MSK_VALID(MSK_VALID)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_msk(wr_msk),
      .wr_data(wr_data), .frame_end(frame_end), .ctl_q(ctl_q),
      .msk_q(msk_q), .qdd_set(qdd_set), .lfd_set(lfd_set)
   );

   dirq_event_decode #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)
   ) u_dec (
      .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_chan(ev_chan),
      .ev_sof_ie(ev_sof_ie), .ev_eof_ie(ev_eof_ie),
      .mask_a(ctl_q[MASK_OFS +: A_NFLAG]), .msk_q(msk_q),
      .set_a(set_a), .set_b(set_b), .berr_hit(berr_hit), .note_hit(note_hit)
   );

   dirq_status_regs #(
      .CH_W(CH_W), .DATA_W(DATA_W), .FID_W(FID_W), .MSK_VALID(MSK_VALID)
   ) u_stat (
      .clk(clk), .rst_n(rst_n), .set_a(set_a), .set_b(set_b),
      .berr_hit(berr_hit), .note_hit(note_hit), .qdd_set(qdd_set),
      .lfd_set(lfd_set), .ev_chan(ev_chan), .ev_fid(ev_fid),
      .wr_sta(wr_sta), .wr_stb(wr_stb), .wr_data(wr_data),
      .st_a(st_a), .st_b(st_b), .fid_q(fid_q)
   );

   assign irq = (|(st_a[A_NFLAG-1:0] & ~ctl_q[MASK_OFS +: A_NFLAG]))
              | (|(st_b & ~msk_q));
   assign enable = ctl_q[CTL_EN];

   always_comb begin
      case (rd_addr)
         ADR_CTL: rd_data = ctl_q;
         ADR_MSK: rd_data = msk_q;
         ADR_STA: rd_data = st_a;
         ADR_STB: rd_data = st_b;
         ADR_FID: rd_data = DATA_W'(fid_q);
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/dirq_checker.sv
module dirq_checker
   import dirq_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int CH_W   = 3,
   parameter int DATA_W = 32,
   parameter int FID_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic [2:0]        ev_kind,
   input logic [CH_W-1:0]   ev_chan,
   input logic [FID_W-1:0]  ev_fid,
   input logic              frame_end,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              irq,
   input logic              enable,
   input logic [DATA_W-1:0] ctl_q,
   input logic [DATA_W-1:0] st_a,
   input logic [DATA_W-1:0] st_b,
   input logic [FID_W-1:0]  fid_q
);

   logic berr_in;
   assign berr_in = ev_valid && (ev_kind == 3'd4)
                 && ({1'b0, ev_chan} < (CH_W+1)'(NUM_CH));

   a_r5_berr_records: assert property (@(posedge clk) disable iff (!rst_n)
      berr_in |=> (st_a[A_BERR] && st_a[A_SUM]
                   && st_a[FIELD_LSB +: CH_W] == $past(ev_chan)
                   && fid_q == $past(ev_fid)));

   a_r6_field_zero_without_err: assert property (@(posedge clk) disable iff (!rst_n)
      !st_a[A_BERR] |-> (st_a[FIELD_LSB +: CH_W] == '0));

   a_r7_quick_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_CTL && enable && !wr_data[CTL_EN]) |=> st_a[A_QDD]);

   a_r8_disable_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && enable && ctl_q[CTL_DAE]) |=> (!enable && st_a[A_LFD]));

   a_r4_fid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> (fid_q == $past(fid_q)));

   a_r3_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((|st_a[A_NFLAG-1:0]) || (|st_b)));

   a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (berr_in && wr_en && wr_addr == ADR_STA) |=> st_a[A_BERR]);

endmodule

bind disp_irq_status dirq_checker #(
   .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .FID_W(FID_W)
) u_dirq_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
   .ev_chan(ev_chan), .ev_fid(ev_fid), .frame_end(frame_end),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq),
   .enable(enable), .ctl_q(ctl_q), .st_a(st_a), .st_b(st_b), .fid_q(fid_q)
);

// File: tb/disp_irq_status_bench.sv
`timescale 1ns/1ps
module disp_irq_status_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [2:0]  ev_kind = '0;
   logic [2:0]  ev_chan = '0;
   logic        ev_sof_ie = 1'b0;
   logic        ev_eof_ie = 1'b0;
   logic [31:0] ev_fid = '0;
   logic        frame_end = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq, enable;

   always #4 clk = ~clk;   // 125 MHz

   disp_irq_status u_disp_irq_status (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_chan(ev_chan), .ev_sof_ie(ev_sof_ie), .ev_eof_ie(ev_eof_ie),
      .ev_fid(ev_fid), .frame_end(frame_end), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq(irq), .enable(enable)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference state
   logic [31:0] m_ctl = 0, m_msk = 0, m_sta = 0, m_stb = 0, m_fid = 0;
   localparam logic [31:0] CTLV = 32'h0000_7F03;
   localparam logic [31:0] MSKV = 32'h3F3F_3F3F;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_reg(input logic [2:0] a);
      case (a)
         3'd0: return m_ctl;
         3'd1: return m_msk;
         3'd2: return m_sta;
         3'd3: return m_stb;
         3'd4: return m_fid;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string reg_tag(input logic [2:0] a);
      case (a)
         3'd0: return "R8 control";
         3'd1: return "R11 mask";
         3'd2: return "R1/R5/R6 primary";
         3'd3: return "R2 secondary";
         3'd4: return "R4 frame id";
         default: return "R11 unused addr";
      endcase
   endfunction

   function automatic logic model_irq();
      logic a, b;
      a = |(m_sta[6:0] & ~m_ctl[14:8]);
      b = |(m_stb & ~m_msk);
      return a | b;
   endfunction

   task automatic compare_all();
      check("R3 irq", {31'b0, irq}, {31'b0, model_irq()});
      check("R8 enable", {31'b0, enable}, {31'b0, m_ctl[0]});
      check(reg_tag(rd_addr), rd_data, model_reg(rd_addr));
   endtask

   task automatic model_apply(input bit ev, input int kind, input int chan, input bit sie,
                              input bit eie, input logic [31:0] fid, input bit fe,
                              input bit we, input int wa, input logic [31:0] wd);
      logic [31:0] n_ctl, n_msk, n_stb, clr_b, set_b;
      logic [11:0] clr_a, set_a, flags;
      logic [2:0]  field;
      bit          note;
      int          bitpos;
      n_ctl = m_ctl; n_msk = m_msk;
      clr_a = '0; set_a = '0; clr_b = '0; set_b = '0;
      field = m_sta[30:28]; note = 1'b0;
      if (we && wa == 0) begin
         n_ctl = wd & CTLV;
         if (m_ctl[0] && !wd[0]) set_a[6] = 1'b1;
      end
      if (we && wa == 1) n_msk = wd & MSKV;
      if (fe && m_ctl[0] && m_ctl[1]) begin
         n_ctl[0] = 1'b0;
         set_a[0] = 1'b1;
      end
      if (we && wa == 2) clr_a = wd[11:0];
      if (we && wa == 3) clr_b = wd & MSKV;
      if (clr_a[2]) field = 3'd0;
      if (ev && chan < 7 && kind <= 4) begin
         if (kind == 4) begin
            set_a[2] = 1'b1;
            field = chan[2:0];
            note = 1'b1;
         end else if (!((kind == 0 && !sie) || (kind == 1 && !eie))) begin
            if (chan == 0) begin
               bitpos = (kind == 0) ? 1 : (kind == 1) ? 3 : (kind == 2) ? 5 : 4;
               set_a[bitpos] = 1'b1;
               if (!m_ctl[8 + bitpos]) note = 1'b1;
            end else begin
               bitpos = kind * 8 + chan - 1;
               set_b[bitpos] = 1'b1;
               if (!m_msk[bitpos]) note = 1'b1;
            end
         end
      end
      if (note) begin
         set_a[7] = 1'b1;
         m_fid = fid;
      end
      flags = (m_sta[11:0] & ~clr_a) | set_a;
      n_stb = (m_stb & ~clr_b) | set_b;
      m_sta = {1'b0, field, 16'h0, flags};
      m_stb = n_stb;
      m_ctl = n_ctl;
      m_msk = n_msk;
   endtask

   // one active clock edge per call
   task automatic step(input bit ev, input int kind, input int chan, input bit sie,
                       input bit eie, input logic [31:0] fid, input bit fe,
                       input bit we, input int wa, input logic [31:0] wd, input int ra);
      @(negedge clk);
      compare_all();
      ev_valid = ev; ev_kind = kind[2:0]; ev_chan = chan[2:0];
      ev_sof_ie = sie; ev_eof_ie = eie; ev_fid = fid; frame_end = fe;
      wr_en = we; wr_addr = wa[2:0]; wr_data = wd; rd_addr = ra[2:0];
      model_apply(ev, kind, chan, sie, eie, fid, fe, we, wa, wd);
      @(posedge clk);
      #1;
      ev_valid = 1'b0; frame_end = 1'b0; wr_en = 1'b0;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      step(0, 0, 0, 0, 0, 0, 0, 1, a, d, 2);
   endtask

   task automatic evt(input int kind, input int chan, input bit sie, input bit eie,
                      input logic [31:0] fid);
      step(1, kind, chan, sie, eie, fid, 0, 0, 0, 0, 2);
   endtask

   task automatic expect_reg(input int a, input logic [31:0] exp, input string tag);
      rd_addr = a[2:0];
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic expect_irq(input bit exp, input string tag);
      #1;
      check(tag, {31'b0, irq}, {31'b0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      for (int a = 0; a < 8; a++) expect_reg(a, 32'h0, "R11 reset register");
      expect_irq(1'b0, "R11 reset irq");
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 + R4: unmasked channel 0 branch
      evt(2, 0, 0, 0, 32'h11);
      expect_reg(2, 32'h0000_00A0, "R1 branch ch0");
      expect_reg(4, 32'h11, "R4 fid load");
      expect_irq(1'b1, "R3 irq unmasked");
      // R6 clear all low bits
      wr(2, 32'hFFFF_FFFF);
      expect_reg(2, 32'h0, "R6 w1c primary");
      expect_irq(1'b0, "R3 irq cleared");
      // R3/R4 masked end-of-frame on ch0
      wr(0, 32'h0000_0800);
      evt(1, 0, 0, 1, 32'h22);
      expect_reg(2, 32'h0000_0008, "R4 masked no summary");
      expect_reg(4, 32'h11, "R4 masked fid kept");
      expect_irq(1'b0, "R3 masked irq low");
      // R9 start-of-frame without its enable
      evt(0, 0, 0, 1, 32'h99);
      expect_reg(2, 32'h0000_0008, "R9 sof gated");
      // R2 secondary placement
      evt(3, 3, 0, 0, 32'h33);
      expect_reg(3, 32'h0400_0000, "R2 underrun ch3");
      expect_reg(2, 32'h0000_0088, "R4 summary secondary");
      expect_reg(4, 32'h33, "R4 fid ch3");
      evt(0, 6, 1, 0, 32'h66);
      expect_reg(3, 32'h0400_0020, "R2 sof ch6");
      // R1 out-of-range channel and reserved kind
      evt(2, 7, 1, 1, 32'h77);
      evt(6, 0, 1, 1, 32'h78);
      expect_reg(3, 32'h0400_0020, "R1 ignored events secondary");
      expect_reg(2, 32'h0000_0088, "R1 ignored events primary");
      wr(3, 32'hFFFF_FFFF);
      expect_reg(3, 32'h0, "R6 w1c secondary");
      wr(2, 32'hFFF);
      // R3 secondary mask
      wr(1, 32'hFFFF_FFFF);
      expect_reg(1, 32'h3F3F_3F3F, "R11 mask bits kept");
      wr(1, 32'h0000_0001);
      evt(0, 1, 1, 0, 32'h44);
      expect_reg(3, 32'h0000_0001, "R2 sof ch1");
      expect_reg(2, 32'h0, "R4 masked ch1 no summary");
      expect_irq(1'b0, "R3 masked secondary");
      // R5 + R10: bus error with a same-cycle clear of its flag
      step(1, 4, 5, 0, 0, 32'h55, 0, 1, 2, 32'h0000_0004, 2);
      expect_reg(2, 32'h5000_0084, "R10 set beats clear");
      expect_reg(4, 32'h55, "R5 fid on bus error");
      wr(2, 32'h0000_0004);
      expect_reg(2, 32'h0000_0080, "R6 field cleared with flag");
      // R7 quick disable
      wr(0, 32'hFFFF_FFFF);
      expect_reg(0, 32'h0000_7F03, "R11 control bits kept");
      wr(0, 32'h0);
      expect_reg(2, 32'h0000_00C0, "R7 quick disable");
      // R8 disable at end
      wr(0, 32'h3);
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      expect_reg(0, 32'h2, "R8 enable self-clear");
      expect_reg(2, 32'h0000_00C1, "R8 last frame done");
      expect_irq(1'b1, "R3 lfd unmasked");
      // R8 ignored while disabled
      wr(2, 32'hFFF);
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 2);
      expect_reg(2, 32'h0, "R8 no flag when disabled");
      // R11 unused address write ignored
      wr(5, 32'hFFFF_FFFF);
      expect_reg(5, 32'h0, "R11 unused address");

      // mixed random traffic against the reference model
      for (int i = 0; i < 6000; i++) begin
         bit ev, fe, we;
         ev = ($urandom_range(0, 1) == 1);
         fe = ($urandom_range(0, 9) == 0);
         we = ($urandom_range(0, 3) == 0);
         step(ev, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom, fe, we, $urandom_range(0, 7),
              ($urandom_range(0, 1) == 1) ? $urandom : 32'h3,
              $urandom_range(0, 7));
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
      @(negedge clk);
      compare_all();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule